// File: doc/BRIEF.md
# Synchronous Clock Stop Gate

This block drives one group of related clock outputs from a source clock that runs at twice the output rate. Each output is a registered toggle: it is high for one source cycle and low for the next. A stop request arrives asynchronously and active low. It is synchronized to the group's own cadence and then stops or restarts the gated outputs, but only at a falling edge of the output clock. A stopped output is therefore held low, and a restarted output always begins with a full-width high phase.

One extra output in the group runs freely and ignores the stop request. Every output, the free one included, has its own enable bit. A cleared enable bit forces that output low. A mode input selects what the shared pins are used for. With mode 0, the stop request is honoured and the two shared pins stay low because they serve as inputs. With mode 1, the stop request is ignored and the shared pins run as two more clock outputs. After a restart, the gated outputs keep running for a minimum time before another stop takes effect. A stop that arrives during that time is held and applied as soon as the time has passed.

Top module: `clk_stop_gate`

## Requirements
- R1: While rst_ni is low, every output is low. After reset, the gate is open, all enables are set, and the gated and free outputs begin pulsing on the first source edge.
- R2: Each running output has a period of two source cycles and is high for exactly one source cycle.
- R3: With mode 0, when stop_ni goes low in the low half-period that follows a falling output edge, the gated outputs give exactly SYNC_STAGES+1 more high pulses and then stay low.
- R4: When stop_ni returns high in that same phase, the gated outputs stay low for SYNC_STAGES+1 periods. After that they give a full high pulse in every period.
- R5: After a restart, the gated outputs keep running for at least MIN_RUN+1 pulses. A stop request that arrives during this time is held and takes effect at the first falling edge after the time has passed.
- R6: clk_free_o is never affected by stop_ni or by the stop state.
- R7: mode_i is sampled at falling output edges. With mode 1, stop_ni is ignored (a stopped group restarts) and each clk_xtra_o pulses in every period. With mode 0, clk_xtra_o is held low.
- R8: en_i bit i enables clk_o[i], and bit N_OUT enables clk_free_o. A 0 bit holds that output low. Outputs with the bit set are unaffected.
- R9: en_i is sampled only at falling output edges. A newly cleared bit lets the pulse in progress finish. Setting a bit while the group is stopped produces no pulse.
- R10: The gate opens and closes only while the outputs are low, so no high phase is ever shortened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x_i | input | 1 | Source clock at twice the output rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0: stop request honoured; 1: shared pins run as extra clocks |
| stop_ni | input | 1 | Asynchronous stop request for the gated outputs, active low |
| en_i | input | N_OUT+1 | Per-output enables; the top bit is for the free output |
| clk_o | output | N_OUT | Gated clock outputs |
| clk_free_o | output | 1 | Free-running clock output |
| clk_xtra_o | output | N_XTRA | Shared-pin clock outputs, active in mode 1 |

## Verification
The bench builds the block with N_OUT=3, N_XTRA=2, SYNC_STAGES=2 and MIN_RUN=10. The short minimum run lets a restart followed at once by a new stop show the exact pulse count of the run window, MIN_RUN+1 = 11, inside a 20-period window. With two synchronizer stages, the off and on latencies come to exact counts of 3. Each pulse-count window is aligned to a falling edge, so every mode, enable and stop change lands in a known phase.

// File: rtl/clk_stop_gate_pkg.sv
package clk_stop_gate_pkg;

  // State of the group gate.
  typedef enum logic {
    GS_RUN  = 1'b0,
    GS_STOP = 1'b1
  } gate_state_e;

endpackage

// File: rtl/clk_stop_gate_sync.sv
// Multi-stage synchronizer that advances once per output period (on tick_i).
module clk_stop_gate_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     chain_q <= RST_VAL;
        else if (tick_i) chain_q <= async_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     chain_q <= {STAGES{RST_VAL}};
        else if (tick_i) chain_q <= {chain_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/clk_stop_gate_ctrl.sv
// Gate controller: open/close decisions at falling output edges, with a minimum run window.
module clk_stop_gate_ctrl
  import clk_stop_gate_pkg::*;
#(
  parameter int unsigned MIN_RUN = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic stop_req_i,
  output logic gate_on_o
);

  localparam int unsigned CW = $clog2(MIN_RUN + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(MIN_RUN);

  // Saturating advance of the run counter.
  function automatic logic [CW-1:0] run_cnt_next(input logic [CW-1:0] c);
    return (c == CNT_MAX) ? c : c + 1'b1;
  endfunction

  // True once the minimum run window has been served.
  function automatic logic run_window_done(input logic [CW-1:0] c);
    return c == CNT_MAX;
  endfunction

  gate_state_e   state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= GS_RUN;
      cnt_q   <= CNT_MAX;
    end else if (tick_i) begin
      unique case (state_q)
        GS_RUN: begin
          if (stop_req_i && run_window_done(cnt_q)) state_q <= GS_STOP;
          else                                      cnt_q   <= run_cnt_next(cnt_q);
        end
        GS_STOP: begin
          if (!stop_req_i) begin
            state_q <= GS_RUN;
            cnt_q   <= '0;
          end
        end
        default: state_q <= GS_STOP;
      endcase
    end
  end

  assign gate_on_o = (state_q == GS_RUN);

endmodule

// File: rtl/clk_stop_gate_out.sv
// Registered output stage: gated, free-running and shared-pin clocks.
module clk_stop_gate_out #(
  parameter int unsigned N_OUT  = 6,
  parameter int unsigned N_XTRA = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             gate_on_i,
  input  logic             mode_q_i,
  input  logic [N_OUT:0]   en_q_i,
  output logic [N_OUT-1:0] clk_o,
  output logic             clk_free_o,
  output logic [N_XTRA-1:0] clk_xtra_o
);

  generate
    for (genvar gi = 0; gi < N_OUT; gi++) begin : g_gated
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) clk_o[gi] <= 1'b0;
        else         clk_o[gi] <= rise_i & gate_on_i & en_q_i[gi];
      end
    end
    for (genvar xi = 0; xi < N_XTRA; xi++) begin : g_xtra
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) clk_xtra_o[xi] <= 1'b0;
        else         clk_xtra_o[xi] <= rise_i & mode_q_i;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clk_free_o <= 1'b0;
    else         clk_free_o <= rise_i & en_q_i[N_OUT];
  end

endmodule

// File: rtl/clk_stop_gate.sv
// Top: phase generator, falling-edge sampling of control inputs, stop synchronizer.
module clk_stop_gate
  import clk_stop_gate_pkg::*;
#(
  parameter int unsigned N_OUT       = 6,
  parameter int unsigned N_XTRA      = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_RUN     = 100
) (
  input  logic              clk2x_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              stop_ni,
  input  logic [N_OUT:0]    en_i,
  output logic [N_OUT-1:0]  clk_o,
  output logic              clk_free_o,
  output logic [N_XTRA-1:0] clk_xtra_o
);

  localparam int unsigned EW = N_OUT + 1;

  // Phase: 1 means the next source edge is a falling output edge.
  logic ph_q;
  logic tick_w;      // this edge ends the high phase
  logic rise_w;      // this edge starts a high phase
  logic mode_q;
  logic [EW-1:0] en_q;
  logic stop_sync_w;
  logic stop_req_w;
  logic gate_on_w;

  always_ff @(posedge clk2x_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= 1'b0;
    else         ph_q <= ~ph_q;
  end

  assign tick_w = ph_q;
  assign rise_w = ~ph_q;

  // Control inputs are taken only at falling output edges.
  always_ff @(posedge clk2x_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      en_q   <= '1;
    end else if (tick_w) begin
      mode_q <= mode_i;
      en_q   <= en_i;
    end
  end

  clk_stop_gate_sync #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_sync (
    .clk_i  (clk2x_i),
    .rst_ni (rst_ni),
    .tick_i (tick_w),
    .async_i(stop_ni),
    .sync_o (stop_sync_w)
  );

  assign stop_req_w = ~mode_q & ~stop_sync_w;

  clk_stop_gate_ctrl #(
    .MIN_RUN(MIN_RUN)
  ) u_ctrl (
    .clk_i     (clk2x_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_w),
    .stop_req_i(stop_req_w),
    .gate_on_o (gate_on_w)
  );

  clk_stop_gate_out #(
    .N_OUT (N_OUT),
    .N_XTRA(N_XTRA)
  ) u_out (
    .clk_i     (clk2x_i),
    .rst_ni    (rst_ni),
    .rise_i    (rise_w),
    .gate_on_i (gate_on_w),
    .mode_q_i  (mode_q),
    .en_q_i    (en_q),
    .clk_o     (clk_o),
    .clk_free_o(clk_free_o),
    .clk_xtra_o(clk_xtra_o)
  );

endmodule

// File: rtl/clk_stop_gate_chk.sv
module clk_stop_gate_chk #(
  parameter int unsigned N_OUT   = 6,
  parameter int unsigned N_XTRA  = 2,
  parameter int unsigned MIN_RUN = 100
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              gate_on_i,
  input logic              mode_q_i,
  input logic [N_OUT:0]    en_q_i,
  input logic [N_OUT-1:0]  clk_o_i,
  input logic              free_i,
  input logic [N_XTRA-1:0] xtra_i
);

  // Independent count of output periods served since the gate last opened.
  int unsigned run_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        run_cnt <= MIN_RUN;
    else if (tick_i) begin
      if (!gate_on_i)   run_cnt <= 0;
      else if (run_cnt < MIN_RUN) run_cnt <= run_cnt + 1;
    end
  end

  p_free_width_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_i |=> !free_i);

  p_high_before_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clk_o_i || free_i) |-> tick_i);

  p_gate_edge_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(gate_on_i) |-> (clk_o_i == '0));

  p_min_run_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(gate_on_i) |-> ($past(run_cnt) >= MIN_RUN));

  p_xtra_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!mode_q_i) |-> (xtra_i == '0));

  p_en_at_fall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(en_q_i) |-> ((clk_o_i == '0) && !free_i));

  p_closed_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!gate_on_i) |-> (clk_o_i == '0));

endmodule

bind clk_stop_gate clk_stop_gate_chk #(
  .N_OUT  (N_OUT),
  .N_XTRA (N_XTRA),
  .MIN_RUN(MIN_RUN)
) u_chk (
  .clk_i    (clk2x_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_w),
  .gate_on_i(gate_on_w),
  .mode_q_i (mode_q),
  .en_q_i   (en_q),
  .clk_o_i  (clk_o),
  .free_i   (clk_free_o),
  .xtra_i   (clk_xtra_o)
);

// File: tb/clk_stop_gate_tb.sv
module clk_stop_gate_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N_OUT  = 3;
  localparam int N_XTRA = 2;
  localparam int SYNC   = 2;
  localparam int MINRUN = 10;
  localparam int WIN    = 16;
  localparam int NVEC   = 12;

  // {mode, stop_n, en[3:0], g0, g1, g2, free, xtra} ; counts of rising edges per window
  localparam logic [45:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 4'hF, 8'd16, 8'd16, 8'd16, 8'd16, 8'd0 },  // R1 runs after reset
    {1'b0, 1'b0, 4'hF, 8'd3,  8'd3,  8'd3,  8'd16, 8'd0 },  // R3 stop
    {1'b0, 1'b0, 4'hF, 8'd0,  8'd0,  8'd0,  8'd16, 8'd0 },  // R3 held
    {1'b0, 1'b1, 4'hF, 8'd13, 8'd13, 8'd13, 8'd16, 8'd0 },  // R4 restart
    {1'b0, 1'b1, 4'hA, 8'd1,  8'd16, 8'd1,  8'd16, 8'd0 },  // R8 enables
    {1'b0, 1'b0, 4'hA, 8'd0,  8'd3,  8'd0,  8'd16, 8'd0 },  // R8 stop with enables
    {1'b0, 1'b0, 4'hF, 8'd0,  8'd0,  8'd0,  8'd16, 8'd0 },  // R9 enable while stopped
    {1'b1, 1'b0, 4'hF, 8'd14, 8'd14, 8'd14, 8'd16, 8'd15},  // R7 mode 1 restarts
    {1'b1, 1'b0, 4'hF, 8'd16, 8'd16, 8'd16, 8'd16, 8'd16},  // R7 stop ignored
    {1'b0, 1'b0, 4'hF, 8'd2,  8'd2,  8'd2,  8'd16, 8'd1 },  // R7 back to mode 0
    {1'b0, 1'b1, 4'h7, 8'd13, 8'd13, 8'd13, 8'd1,  8'd0 },  // R8 free disabled
    {1'b0, 1'b1, 4'hF, 8'd16, 8'd16, 8'd16, 8'd15, 8'd0 }   // R9 free re-enabled
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              mode;
  logic              stop_n;
  logic [N_OUT:0]    en;
  logic [N_OUT-1:0]  clk_o;
  logic              clk_free_o;
  logic [N_XTRA-1:0] clk_xtra_o;

  clk_stop_gate #(
    .N_OUT(N_OUT), .N_XTRA(N_XTRA), .SYNC_STAGES(SYNC), .MIN_RUN(MINRUN)
  ) dut_i (
    .clk2x_i(clk), .rst_ni(rst_n), .mode_i(mode), .stop_ni(stop_n), .en_i(en),
    .clk_o(clk_o), .clk_free_o(clk_free_o), .clk_xtra_o(clk_xtra_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  int cnt_g [N_OUT];
  int cnt_x [N_XTRA];
  int cnt_f, hi_f, hi_g0;
  logic [N_OUT-1:0]  prev_g;
  logic [N_XTRA-1:0] prev_x;
  logic              prev_f;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_counts();
    for (int i = 0; i < N_OUT; i++) cnt_g[i] = 0;
    for (int i = 0; i < N_XTRA; i++) cnt_x[i] = 0;
    cnt_f = 0; hi_f = 0; hi_g0 = 0;
    prev_g = clk_o; prev_x = clk_xtra_o; prev_f = clk_free_o;
  endtask

  // Count rising edges over ngc output periods, sampling at falling source edges.
  task automatic count_for(input int ngc);
    for (int k = 0; k < 2*ngc; k++) begin
      @(negedge clk);
      for (int i = 0; i < N_OUT; i++) if (clk_o[i] && !prev_g[i]) cnt_g[i]++;
      for (int i = 0; i < N_XTRA; i++) if (clk_xtra_o[i] && !prev_x[i]) cnt_x[i]++;
      if (clk_free_o && !prev_f) cnt_f++;
      if (clk_free_o) hi_f++;
      if (clk_o[0]) hi_g0++;
      prev_g = clk_o; prev_x = clk_xtra_o; prev_f = clk_free_o;
    end
  endtask

  function automatic string vec_req(input int vi);
    case (vi)
      0: return "R1";
      1, 2: return "R3";
      3: return "R4";
      4, 5, 10: return "R8";
      6, 11: return "R9";
      default: return "R7";
    endcase
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode = 1'b0; stop_n = 1'b1; en = '1;
    repeat (3) @(negedge clk);
    // R1: all outputs low in reset
    chk("R1", "clk_o in reset", int'(clk_o), 0);
    chk("R1", "clk_free_o in reset", int'(clk_free_o), 0);
    chk("R1", "clk_xtra_o in reset", int'(clk_xtra_o), 0);
    rst_n = 1'b1;
    // align: next source edge starts a high phase
    do @(negedge clk); while (!clk_free_o);
    @(negedge clk);

    for (int vi = 0; vi < NVEC; vi++) begin
      mode   = VEC[vi][45];
      stop_n = VEC[vi][44];
      en     = VEC[vi][43:40];
      clear_counts();
      count_for(WIN);
      chk(vec_req(vi), $sformatf("v%0d clk_o[0] pulses", vi), cnt_g[0], int'(VEC[vi][39:32]));
      chk(vec_req(vi), $sformatf("v%0d clk_o[1] pulses", vi), cnt_g[1], int'(VEC[vi][31:24]));
      chk(vec_req(vi), $sformatf("v%0d clk_o[2] pulses", vi), cnt_g[2], int'(VEC[vi][23:16]));
      chk("R6", $sformatf("v%0d clk_free_o pulses", vi), cnt_f, int'(VEC[vi][15:8]));
      for (int i = 0; i < N_XTRA; i++)
        chk("R7", $sformatf("v%0d clk_xtra_o[%0d] pulses", vi, i), cnt_x[i], int'(VEC[vi][7:0]));
      if (vi == 0) begin
        // R2: each pulse lasts one source cycle
        chk("R2", "free high samples equal pulses", hi_f, cnt_f);
        chk("R2", "clk_o[0] high samples equal pulses", hi_g0, cnt_g[0]);
      end
      if (vi == 1)
        chk("R10", "closing window: high samples equal pulses", hi_g0, cnt_g[0]);
    end

    // R5: restart then immediate new stop request; run lasts MIN_RUN+1 pulses
    stop_n = 1'b0;
    clear_counts();
    count_for(WIN);
    chk("R3", "stop before min-run test", cnt_g[0], SYNC + 1);
    stop_n = 1'b1;
    clear_counts();
    count_for(2);
    stop_n = 1'b0;
    count_for(18);
    chk("R5", "pulses in min run window", cnt_g[0], MINRUN + 1);
    chk("R5", "clk_o[2] pulses in min run window", cnt_g[2], MINRUN + 1);
    chk("R10", "min run high samples equal pulses", hi_g0, cnt_g[0]);
    chk("R6", "free pulses across min run", cnt_f, 20);
    clear_counts();
    count_for(WIN);
    chk("R5", "pending stop applied, held low", cnt_g[0] + cnt_g[1] + cnt_g[2], 0);

    // R4: restart latency, no pulse during SYNC+1 periods then continuous
    stop_n = 1'b1;
    clear_counts();
    count_for(SYNC + 1);
    chk("R4", "no pulse during on latency", cnt_g[0], 0);
    count_for(4);
    chk("R4", "pulses after on latency", cnt_g[0], 4);

    done = 1;
    summary();
    $finish;
  end

endmodule